// File: doc/BRIEF.md
# CPU Halt and Wake Controller

This block puts a small microcontroller core to sleep and wakes it again. When the core decodes a HALT instruction it raises a one-cycle halt request. The controller then sets a halt flag, and that flag holds instruction fetch stalled until one of two events ends the halt. The first event is an interrupt request from a source whose own enable bit is set, which returns the core to normal running. The second is a high level on the external reset pin, which sends the core into system reset.

After an interrupt wakes the core, the core runs exactly one instruction: the one placed right after HALT. Only once that instruction retires does the controller decide whether to vector. A one-cycle interrupt-accept strobe goes out only when the master interrupt enable is set at that moment. If the master enable is clear, the core simply keeps running. The master enable plays no part in deciding whether the core wakes. Priority encoding, the vector table and the datapath are left to neighbouring blocks.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After that edge `halt_flag`, `fetch_stall`, `int_accept` and `sys_reset_req` are all 0.
- R2: In the running state, a high `halt_req` at a clock edge sets `halt_flag` after that edge. `fetch_stall` equals `halt_flag` in every cycle.
- R3: While halted, if any bit of `irq_req & irq_en` is 1 at a clock edge, `halt_flag` is 0 after that edge.
- R4: A request on a source whose `irq_en` bit is 0 never clears `halt_flag`.
- R5: `master_ie` has no effect on whether the core wakes. Wake-up happens with `master_ie` at 0 just as it does with `master_ie` at 1.
- R6: After an interrupt wake-up, `int_accept` stays 0 until the first clock edge where `instr_done` is 1. If `master_ie` is 1 at that edge, `int_accept` is 1 for exactly the following cycle.
- R7: If `master_ie` is 0 at the edge where the post-wake instruction retires, `int_accept` stays 0 and the block returns to the running state.
- R8: A high `reset_pin` clears `halt_flag` and `int_accept` at once, without waiting for a clock. It also wins over any enabled request in the same cycle.
- R9: `sys_reset_req` follows `reset_pin` through a chain of `SYNC_STAGES` clocked stages, so it changes `SYNC_STAGES` edges after the pin changes.
- R10: If an enabled request is already pending when HALT executes, `halt_flag` is high for exactly one cycle.
- R11: A `halt_req` that arrives while the block waits for the post-wake instruction is ignored, and `halt_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| reset_pin | input | 1 | External reset pin, active high, asynchronous clear of the halt logic |
| halt_req | input | 1 | One-cycle pulse: a HALT instruction was executed |
| irq_req | input | NUM_SRC | Per-source interrupt request levels |
| irq_en | input | NUM_SRC | Per-source interrupt enable bits |
| master_ie | input | 1 | Master interrupt enable; gates vectoring only |
| instr_done | input | 1 | Pulse: the core retired an instruction |
| halt_flag | output | 1 | Halt flag status bit |
| fetch_stall | output | 1 | Stall instruction fetch |
| int_accept | output | 1 | One-cycle strobe: vector to the interrupt now |
| sys_reset_req | output | 1 | Synchronised system-reset request |

## Verification
The bench builds the block with eight interrupt sources and a two-stage reset chain. Eight sources make it likely that random requests fall on masked lines. That tests masking against single-bit and multi-bit overlaps between the request and enable vectors. With two stages, the reset-request delay is short enough to check at every edge while the pin toggles at random. The delay is still long enough to tell an off-by-one delay from the correct one. Directed cases cover a request that is already pending at HALT and an asynchronous pin assertion between clock edges.

// File: rtl/hwc_pkg.sv
// Shared types for the halt and wake controller.
package hwc_pkg;

    // Sequencer states: running, halted, waiting for the post-wake instruction.
    typedef enum logic [1:0] {
        HW_RUN  = 2'd0,
        HW_HALT = 2'd1,
        HW_STEP = 2'd2
    } hw_state_e;

endpackage

// File: rtl/hwc_wake_detect.sv
// Wake detector: reports that at least one source has both its request
// and its individual enable set. Assumes request inputs are already
// synchronous levels. The master enable is deliberately not an input.
module hwc_wake_detect #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    output logic               wake
);

    logic [NUM_SRC-1:0] gated;

    // Per-source qualification of each request by its own enable bit.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign gated[g] = irq_req[g] & irq_en[g];
    end

    // Any qualified source wakes the core.
    always_comb wake = |gated;

endmodule

// File: rtl/hwc_reset_sync.sv
// Reset-request synchroniser: passes the external pin through STAGES
// flops. Assumes STAGES >= 1. Cleared by the synchronous block reset.
module hwc_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin;
    end

    // Remaining stages shift the sample along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/hwc_halt_fsm.sv
// Halt sequencer: enters halt on a HALT pulse, leaves it on a wake
// indication, lets one instruction retire, and then issues the accept
// strobe if the master enable allows it. The external pin clears
// everything asynchronously and overrides the synchronous reset.
module hwc_halt_fsm
    import hwc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reset_pin,
    input  logic halt_req,
    input  logic wake,
    input  logic instr_done,
    input  logic master_ie,
    output logic halt_flag,
    output logic int_accept
);

    hw_state_e state_q, state_d;
    logic      accept_d;

    // Next-state and strobe decode.
    always_comb begin
        state_d  = state_q;
        accept_d = 1'b0;
        unique case (state_q)
            HW_RUN:  if (halt_req) state_d = HW_HALT;
            HW_HALT: if (wake)     state_d = HW_STEP;
            HW_STEP: if (instr_done) begin
                state_d  = HW_RUN;
                accept_d = master_ie;
            end
            default: state_d = HW_RUN;
        endcase
    end

    // State and strobe registers; pin clears asynchronously.
    always_ff @(posedge clk or posedge reset_pin) begin
        if (reset_pin) begin
            state_q    <= HW_RUN;
            int_accept <= 1'b0;
        end else if (!rst_n) begin
            state_q    <= HW_RUN;
            int_accept <= 1'b0;
        end else begin
            state_q    <= state_d;
            int_accept <= accept_d;
        end
    end

    assign halt_flag = (state_q == HW_HALT);

endmodule

// File: rtl/halt_wake_ctrl.sv
// Top of the halt and wake controller. Assumes halt_req and instr_done
// are single-cycle pulses from the core and that irq_req is synchronous.
module halt_wake_ctrl #(
    parameter int NUM_SRC     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_pin,
    input  logic               halt_req,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               master_ie,
    input  logic               instr_done,
    output logic               halt_flag,
    output logic               fetch_stall,
    output logic               int_accept,
    output logic               sys_reset_req
);

    logic wake;

    hwc_wake_detect #(.NUM_SRC(NUM_SRC)) i_wake (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .wake    (wake)
    );

    hwc_halt_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .reset_pin  (reset_pin),
        .halt_req   (halt_req),
        .wake       (wake),
        .instr_done (instr_done),
        .master_ie  (master_ie),
        .halt_flag  (halt_flag),
        .int_accept (int_accept)
    );

    hwc_reset_sync #(.STAGES(SYNC_STAGES)) i_rsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (reset_pin),
        .sync_out (sys_reset_req)
    );

    // Fetch is held off for as long as the halt flag is set.
    assign fetch_stall = halt_flag;

endmodule

// File: rtl/halt_wake_ctrl_chk.sv
// Property checker for the halt and wake controller, bound to the top.
module halt_wake_ctrl_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reset_pin,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [NUM_SRC-1:0] irq_en,
    input logic               master_ie,
    input logic               halt_flag,
    input logic               int_accept
);

    p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n || reset_pin)
        (halt_flag && |(irq_req & irq_en)) |=> !halt_flag);

    p_masked_no_wake_r4: assert property (@(posedge clk) disable iff (!rst_n || reset_pin)
        (halt_flag && !(|(irq_req & irq_en))) |=> halt_flag);

    p_accept_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n || reset_pin)
        int_accept |=> !int_accept);

    p_no_accept_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_flag |-> !int_accept);

    p_accept_gate_r7: assert property (@(posedge clk) disable iff (!rst_n || reset_pin)
        int_accept |-> $past(master_ie));

    p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pin |-> (!halt_flag && !int_accept));

endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk #(.NUM_SRC(NUM_SRC)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_pin  (reset_pin),
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .master_ie  (master_ie),
    .halt_flag  (halt_flag),
    .int_accept (int_accept)
);

// File: tb/test_halt_wake_ctrl.sv
module test_halt_wake_ctrl;

    localparam int NSRC = 8;
    localparam int NSYN = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reset_pin = 1'b0;
    logic            halt_req = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic [NSRC-1:0] irq_en = '0;
    logic            master_ie = 1'b0;
    logic            instr_done = 1'b0;
    logic            halt_flag, fetch_stall, int_accept, sys_reset_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model: 0 run, 1 halt, 2 step.
    int              m_st = 0;
    logic            m_acc = 1'b0;
    logic [NSYN-1:0] m_sync = '0;

    halt_wake_ctrl #(.NUM_SRC(NSRC), .SYNC_STAGES(NSYN)) i_halt_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .reset_pin(reset_pin), .halt_req(halt_req),
        .irq_req(irq_req), .irq_en(irq_en), .master_ie(master_ie),
        .instr_done(instr_done), .halt_flag(halt_flag), .fetch_stall(fetch_stall),
        .int_accept(int_accept), .sys_reset_req(sys_reset_req)
    );

    always #10 clk = ~clk;

    // Model update from the requirements, on the same edge as the design.
    always @(posedge clk) begin
        if (reset_pin) begin
            m_st = 0; m_acc = 1'b0;
        end else if (!rst_n) begin
            m_st = 0; m_acc = 1'b0;
        end else begin
            m_acc = 1'b0;
            case (m_st)
                0: if (halt_req) m_st = 1;
                1: if (|(irq_req & irq_en)) m_st = 2;
                2: if (instr_done) begin m_acc = master_ie; m_st = 0; end
                default: m_st = 0;
            endcase
        end
        if (!rst_n) m_sync = '0;
        else        m_sync = {m_sync[NSYN-2:0], reset_pin};
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic exp_halt();
        return m_st == 1;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "halt_flag", halt_flag, exp_halt());
        chk(req, "fetch_stall", fetch_stall, exp_halt());
        chk(req, "int_accept", int_accept, m_acc);
        chk(req, "sys_reset_req", sys_reset_req, m_sync[NSYN-1]);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; halt_req = 1'b0; instr_done = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1", "halt_flag", halt_flag, 1'b0);
        chk("R1", "fetch_stall", fetch_stall, 1'b0);
        chk("R1", "int_accept", int_accept, 1'b0);
        chk("R1", "sys_reset_req", sys_reset_req, 1'b0);

        // R2 entry; R4/R5 masked requests with master enable high
        halt_req = 1'b1; cyc(); halt_req = 1'b0;
        chk("R2", "halt_flag", halt_flag, 1'b1);
        irq_req = 8'hF0; irq_en = 8'h0F; master_ie = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk("R4", "halt_flag", halt_flag, 1'b1);
            chk("R2", "fetch_stall", fetch_stall, 1'b1);
        end

        // R5: wake with master enable low; R7: no accept
        master_ie = 1'b0; irq_req = 8'h04; cyc();
        chk("R5", "halt_flag", halt_flag, 1'b0);
        irq_req = '0; instr_done = 1'b1; cyc(); instr_done = 1'b0;
        chk("R7", "int_accept", int_accept, 1'b0);
        cyc();
        chk("R7", "int_accept", int_accept, 1'b0);

        // R6: delayed retire, accept pulse exactly once
        halt_req = 1'b1; cyc(); halt_req = 1'b0;
        master_ie = 1'b1; irq_en = 8'h80; irq_req = 8'h80; cyc(); irq_req = '0;
        chk("R3", "halt_flag", halt_flag, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R6", "int_accept early", int_accept, 1'b0);
        end
        // R11: HALT while waiting for the step instruction is ignored
        halt_req = 1'b1; cyc(); halt_req = 1'b0;
        chk("R11", "halt_flag", halt_flag, 1'b0);
        instr_done = 1'b1; cyc(); instr_done = 1'b0;
        chk("R6", "int_accept", int_accept, 1'b1);
        cyc();
        chk("R6", "int_accept width", int_accept, 1'b0);

        // R10: request already pending at HALT
        irq_en = 8'h01; irq_req = 8'h01;
        halt_req = 1'b1; cyc(); halt_req = 1'b0;
        chk("R10", "halt_flag first", halt_flag, 1'b1);
        cyc();
        chk("R10", "halt_flag second", halt_flag, 1'b0);
        instr_done = 1'b1; cyc(); instr_done = 1'b0; irq_req = '0;
        cyc();

        // R8: asynchronous clear with an enabled request present; R9 delay
        halt_req = 1'b1; cyc(); halt_req = 1'b0;
        chk("R8", "halt_flag before", halt_flag, 1'b1);
        #5 irq_req = 8'h01; reset_pin = 1'b1; m_st = 0; m_acc = 1'b0;
        #1 chk("R8", "halt_flag async", halt_flag, 1'b0);
        @(negedge clk);
        chk("R9", "sys_reset_req stage1", sys_reset_req, 1'b0);
        cyc();
        chk("R9", "sys_reset_req stage2", sys_reset_req, 1'b1);
        reset_pin = 1'b0; irq_req = '0;
        cyc();
        chk("R9", "sys_reset_req hold", sys_reset_req, 1'b1);
        cyc();
        chk("R9", "sys_reset_req drop", sys_reset_req, 1'b0);

        // Random phase against the model (R2-R9).
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            halt_req   = ($urandom % 4) == 0;
            instr_done = ($urandom % 3) == 0;
            master_ie  = $urandom % 2;
            irq_en     = NSRC'($urandom);
            irq_req    = (($urandom % 4) == 0) ? NSRC'($urandom) : '0;
            if (($urandom % 64) == 0) begin
                reset_pin = ~reset_pin;
                if (reset_pin) begin m_st = 0; m_acc = 1'b0; end
            end
            cyc();
            chk_all("R2-model");
            chk("R3", "model wake", halt_flag, exp_halt());
        end
        reset_pin = 1'b0;
        cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule